// File: doc/BRIEF.md
# Branch and call control unit

This unit resolves the program-flow instructions of a 16-bit instruction set. Each cycle it may accept one instruction word together with the address of that instruction, the value read from the general register file, the current link register value and the four condition flags. One clock later it presents the address of the next instruction, a write request and data for the link register, a flag saying that control left the sequential path, and the number of cycles the instruction costs in the pipeline.

The instructions it handles are:

- an unconditional branch and a never-branch;
- fourteen branches that test the negative (N), zero (Z), overflow (V) and carry (C) flags, including signed and unsigned magnitude comparisons;
- a call with an 11-bit relative displacement;
- register-indirect jump and call;
- return through the link register.

Relative displacements count halfwords and are taken from the address of the following instruction. Any other encoding is flagged as illegal and falls through to the next sequential address.

The register index field of the instruction is passed straight out so that the surrounding pipeline can drive the register file read port in the same cycle.

Top module: `bcu_flow`

## Requirements
- R1: While rst_n is low, out_valid, pc_next, rp_we, rp_wdata, taken, cycles and illegal are all zero.
- R2: The outputs for an instruction presented with in_valid high appear on the clock edge that samples it. In a cycle after in_valid was low, out_valid is 0 and every other registered output is 0.
- R3: Words whose upper byte is 0xE0 to 0xEF are conditional branches. The flags input is ordered N=bit3, Z=bit2, V=bit1, C=bit0. The branch conditions by upper byte are:
  - 0xE0 always; 0xE1 never.
  - 0xE2 Z; 0xE3 not Z.
  - 0xE4 C; 0xE5 not C.
  - 0xE6 N; 0xE7 not N.
  - 0xE8 V; 0xE9 not V.
  - 0xEA V^N; 0xEB not (V^N).
  - 0xEC (V^N)|Z; 0xED not ((V^N)|Z).
  - 0xEE C|Z; 0xEF not (C|Z).
- R4: A taken branch gives pc_next = PC + 2 + 2×sext(instr[7:0]) and taken = 1. A branch that is not taken gives pc_next = PC + 2 and taken = 0. Neither writes the link register.
- R5: A taken branch costs 2 cycles and a branch that is not taken costs 1. This includes 0xE0, which always costs 2, and 0xE1, which always costs 1.
- R6: A word with instr[15:11] = 11010 is a relative call:
  - pc_next = PC + 2 + 2×sext(instr[10:0]);
  - rp_we = 1 and rp_wdata = PC + 2;
  - taken = 1 and cycles = 2.
- R7: Upper byte 0x97 with instr[7:4] = 0 is an indirect jump: pc_next = ri_val, rp_we = 0, taken = 1, cycles = 2. The ri_sel output always equals instr[3:0] in the same cycle.
- R8: Upper byte 0x97 with instr[7:4] = 1 is an indirect call:
  - pc_next = ri_val;
  - rp_we = 1 and rp_wdata = PC + 2;
  - taken = 1 and cycles = 2.
- R9: Upper byte 0x97 with instr[7:4] = 2 is a return: pc_next = rp_cur, rp_we = 0, taken = 1, cycles = 2.
- R10: Every other encoding, including 0x97 with instr[7:4] of 3 or more, gives illegal = 1 with pc_next = PC + 2, taken = 0, rp_we = 0 and cycles = 1. All decoded forms give illegal = 0.
- R11: All address arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pc_cur | input | PC_W | Address of the instruction |
| ri_val | input | PC_W | Register file value selected by ri_sel |
| rp_cur | input | PC_W | Current link register value |
| flags | input | 4 | Condition flags N, Z, V, C (bit 3 to bit 0) |
| ri_sel | output | 4 | Register index field, combinational from instr |
| out_valid | output | 1 | Registered outputs belong to an instruction |
| pc_next | output | PC_W | Address of the next instruction |
| rp_we | output | 1 | Link register write enable |
| rp_wdata | output | PC_W | Link register write data |
| taken | output | 1 | Control left the sequential path |
| cycles | output | CYC_W | Cycle cost of the instruction |
| illegal | output | 1 | Encoding not recognised |

## Verification
The hardest cases to reach are the compound signed and unsigned conditions: each depends on particular combinations of two or three flags. A random flag pattern seldom exercises both polarities of every one of them together with both signs of the displacement. The stimulus therefore sweeps every condition code against all sixteen flag patterns, with a negative displacement on even sweeps and a positive one on odd sweeps. Addresses near zero and near the top of the address space are chosen so that forward and backward targets wrap. A random phase then mixes in calls, returns, undecoded indirect sub-operations and idle cycles.

// File: rtl/bcu_pkg.sv
`timescale 1ns/1ps
package bcu_pkg;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_V = 1;
   localparam int FLG_C = 0;

   localparam logic [3:0]  COND_HI   = 4'hE;
   localparam logic [4:0]  CALLR_HI  = 5'b11010;
   localparam logic [7:0]  INDIR_HI  = 8'h97;
   localparam logic [3:0]  SUB_JUMP  = 4'd0;
   localparam logic [3:0]  SUB_CALL  = 4'd1;
   localparam logic [3:0]  SUB_RET   = 4'd2;

   typedef enum logic [2:0] {
      K_BRANCH,
      K_CALL_REL,
      K_JUMP_IND,
      K_CALL_IND,
      K_RETURN,
      K_ILLEGAL
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic [3:0] cc;
      logic [3:0] ridx;
   } decode_t;

   // Base term of a condition pair; odd codes take its inverse.
   function automatic logic pair_term(input int p, input logic [3:0] f);
      logic n, z, v, c;
      n = f[FLG_N];
      z = f[FLG_Z];
      v = f[FLG_V];
      c = f[FLG_C];
      case (p)
         0:       pair_term = 1'b1;
         1:       pair_term = z;
         2:       pair_term = c;
         3:       pair_term = n;
         4:       pair_term = v;
         5:       pair_term = v ^ n;
         6:       pair_term = (v ^ n) | z;
         default: pair_term = c | z;
      endcase
   endfunction

endpackage

// File: rtl/bcu_decode.sv
`timescale 1ns/1ps
module bcu_decode
   import bcu_pkg::*;
(
   input  logic [15:0] instr,
   output decode_t     dec
);

   logic is_cond, is_callr, is_indir;

   always_comb begin
      is_cond  = (instr[15:12] == COND_HI);
      is_callr = (instr[15:11] == CALLR_HI);
      is_indir = (instr[15:8]  == INDIR_HI);
   end

   always_comb begin
      dec.cc   = instr[11:8];
      dec.ridx = instr[3:0];
      if (is_cond) begin
         dec.kind = K_BRANCH;
      end else if (is_callr) begin
         dec.kind = K_CALL_REL;
      end else if (is_indir) begin
         case (instr[7:4])
            SUB_JUMP: dec.kind = K_JUMP_IND;
            SUB_CALL: dec.kind = K_CALL_IND;
            SUB_RET:  dec.kind = K_RETURN;
            default:  dec.kind = K_ILLEGAL;
         endcase
      end else begin
         dec.kind = K_ILLEGAL;
      end
   end

   // R10: the opcode groups never overlap
   always_comb begin
      groups_disjoint_chk: assert ($onehot0({is_cond, is_callr, is_indir}));
   end

endmodule

// File: rtl/bcu_cond.sv
`timescale 1ns/1ps
module bcu_cond
   import bcu_pkg::*;
#(
   parameter int N_CODES = 16
) (
   input  logic [3:0] flags,
   input  logic [3:0] cc,
   output logic       hit
);

   localparam int N_PAIRS = N_CODES / 2;

   initial begin
      codes_chk: assert (N_CODES == 16)
         else $error("bcu_cond: N_CODES must be 16");
   end

   logic [N_PAIRS-1:0] base;

   for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
      assign base[p] = pair_term(p, flags);
   end

   assign hit = base[cc[3:1]] ^ cc[0];

endmodule

// File: rtl/bcu_target.sv
`timescale 1ns/1ps
module bcu_target #(
   parameter int PC_W   = 32,
   parameter int DISP_W = 8
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   seq,
   output logic [PC_W-1:0]   tgt
);

   localparam int EXT_W = PC_W - DISP_W - 1;

   initial begin
      width_chk: assert (EXT_W >= 1)
         else $error("bcu_target: PC_W too small for DISP_W");
   end

   logic [PC_W-1:0] offs;

   assign offs = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
   assign seq  = pc + PC_W'(2);
   assign tgt  = seq + offs;

endmodule

// File: rtl/bcu_flow.sv
`timescale 1ns/1ps
module bcu_flow
   import bcu_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int CYC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [15:0]      instr,
   input  logic [PC_W-1:0]  pc_cur,
   input  logic [PC_W-1:0]  ri_val,
   input  logic [PC_W-1:0]  rp_cur,
   input  logic [3:0]       flags,
   output logic [3:0]       ri_sel,
   output logic             out_valid,
   output logic [PC_W-1:0]  pc_next,
   output logic             rp_we,
   output logic [PC_W-1:0]  rp_wdata,
   output logic             taken,
   output logic [CYC_W-1:0] cycles,
   output logic             illegal
);

   localparam logic [CYC_W-1:0] CYC_SHORT = CYC_W'(1);
   localparam logic [CYC_W-1:0] CYC_LONG  = CYC_W'(2);

   initial begin
      pcw_chk: assert (PC_W >= 13)
         else $error("bcu_flow: PC_W must hold an 11-bit halfword offset");
      cycw_chk: assert (CYC_W >= 2)
         else $error("bcu_flow: CYC_W must hold the value 2");
   end

   decode_t         dec;
   logic            cond_hit;
   logic [PC_W-1:0] seq_a, tgt_b, seq_c, tgt_c;

   bcu_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   bcu_cond #(.N_CODES(16)) u_cond (
      .flags (flags),
      .cc    (dec.cc),
      .hit   (cond_hit)
   );

   bcu_target #(.PC_W(PC_W), .DISP_W(8)) u_tgt_br (
      .pc   (pc_cur),
      .disp (instr[7:0]),
      .seq  (seq_a),
      .tgt  (tgt_b)
   );

   bcu_target #(.PC_W(PC_W), .DISP_W(11)) u_tgt_call (
      .pc   (pc_cur),
      .disp (instr[10:0]),
      .seq  (seq_c),
      .tgt  (tgt_c)
   );

   assign ri_sel = dec.ridx;

   logic [PC_W-1:0]  n_pc, n_rpd;
   logic             n_we, n_tk, n_ill;
   logic [CYC_W-1:0] n_cyc;

   always_comb begin
      n_pc  = seq_a;
      n_rpd = '0;
      n_we  = 1'b0;
      n_tk  = 1'b0;
      n_ill = 1'b0;
      n_cyc = CYC_SHORT;
      case (dec.kind)
         K_BRANCH: begin
            n_tk  = cond_hit;
            n_pc  = cond_hit ? tgt_b : seq_a;
            n_cyc = cond_hit ? CYC_LONG : CYC_SHORT;
         end
         K_CALL_REL: begin
            n_tk  = 1'b1;
            n_pc  = tgt_c;
            n_we  = 1'b1;
            n_rpd = seq_c;
            n_cyc = CYC_LONG;
         end
         K_JUMP_IND: begin
            n_tk  = 1'b1;
            n_pc  = ri_val;
            n_cyc = CYC_LONG;
         end
         K_CALL_IND: begin
            n_tk  = 1'b1;
            n_pc  = ri_val;
            n_we  = 1'b1;
            n_rpd = seq_a;
            n_cyc = CYC_LONG;
         end
         K_RETURN: begin
            n_tk  = 1'b1;
            n_pc  = rp_cur;
            n_cyc = CYC_LONG;
         end
         default: begin
            n_ill = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pc_next   <= '0;
         rp_we     <= 1'b0;
         rp_wdata  <= '0;
         taken     <= 1'b0;
         cycles    <= '0;
         illegal   <= 1'b0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         pc_next   <= n_pc;
         rp_we     <= n_we;
         rp_wdata  <= n_rpd;
         taken     <= n_tk;
         cycles    <= n_cyc;
         illegal   <= n_ill;
      end else begin
         out_valid <= 1'b0;
         pc_next   <= '0;
         rp_we     <= 1'b0;
         rp_wdata  <= '0;
         taken     <= 1'b0;
         cycles    <= '0;
         illegal   <= 1'b0;
      end
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!rp_we && !taken && !illegal));

   // R5
   cycle_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cycles == (taken ? CYC_LONG : CYC_SHORT)));

   // R6
   link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_we |-> (rp_wdata == $past(pc_cur) + PC_W'(2)));

   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!taken && !rp_we && pc_next == $past(pc_cur) + PC_W'(2)));

endmodule

// File: tb/sim_bcu_flow.sv
`timescale 1ns/1ps
module sim_bcu_flow;

   localparam int PC_W  = 32;
   localparam int CYC_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [15:0]      instr = '0;
   logic [PC_W-1:0]  pc_cur = '0, ri_val = '0, rp_cur = '0;
   logic [3:0]       flags = '0;
   logic [3:0]       ri_sel;
   logic             out_valid, rp_we, taken, illegal;
   logic [PC_W-1:0]  pc_next, rp_wdata;
   logic [CYC_W-1:0] cycles;

   int compared = 0;
   int mismatched = 0;

   // Expected outputs for the next compare
   logic [31:0] e_pc, e_rpd;
   logic        e_val, e_we, e_tk, e_ill;
   logic [1:0]  e_cyc;
   string       e_tag;

   always #2.5 clk = ~clk;

   bcu_flow #(.PC_W(PC_W), .CYC_W(CYC_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .pc_cur(pc_cur), .ri_val(ri_val), .rp_cur(rp_cur), .flags(flags),
      .ri_sel(ri_sel), .out_valid(out_valid), .pc_next(pc_next),
      .rp_we(rp_we), .rp_wdata(rp_wdata), .taken(taken),
      .cycles(cycles), .illegal(illegal)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic cond_ref(input logic [3:0] code, input logic [3:0] f);
      logic n, z, v, c;
      n = f[3]; z = f[2]; v = f[1]; c = f[0];
      case (code)
         4'h0: return 1'b1;
         4'h1: return 1'b0;
         4'h2: return z;
         4'h3: return !z;
         4'h4: return c;
         4'h5: return !c;
         4'h6: return n;
         4'h7: return !n;
         4'h8: return v;
         4'h9: return !v;
         4'hA: return v ^ n;
         4'hB: return !(v ^ n);
         4'hC: return (v ^ n) | z;
         4'hD: return !((v ^ n) | z);
         4'hE: return c | z;
         default: return !(c | z);
      endcase
   endfunction

   task automatic set_idle_exp(input string tag);
      e_val = 0; e_pc = 0; e_we = 0; e_rpd = 0; e_tk = 0; e_cyc = 0; e_ill = 0;
      e_tag = tag;
   endtask

   task automatic model(input logic v, input logic [15:0] ins, input logic [31:0] pc,
                        input logic [31:0] ri, input logic [31:0] rp,
                        input logic [3:0] f, input string force_tag);
      int d;
      if (!v) begin
         set_idle_exp("R2");
         return;
      end
      e_val = 1; e_we = 0; e_rpd = 0; e_tk = 0; e_ill = 0; e_cyc = 1;
      e_pc = pc + 32'd2;
      if (ins[15:12] == 4'hE) begin
         e_tag = "R3/R4/R5";
         if (cond_ref(ins[11:8], f)) begin
            d = int'($signed(ins[7:0]));
            e_pc = pc + 32'd2 + 32'(d * 2);
            e_tk = 1; e_cyc = 2;
         end
      end else if (ins[15:11] == 5'b11010) begin
         e_tag = "R6";
         d = ins[10] ? int'(ins[10:0]) - 2048 : int'(ins[10:0]);
         e_pc = pc + 32'd2 + 32'(d * 2);
         e_we = 1; e_rpd = pc + 32'd2; e_tk = 1; e_cyc = 2;
      end else if (ins[15:8] == 8'h97 && ins[7:4] == 4'd0) begin
         e_tag = "R7";
         e_pc = ri; e_tk = 1; e_cyc = 2;
      end else if (ins[15:8] == 8'h97 && ins[7:4] == 4'd1) begin
         e_tag = "R8";
         e_pc = ri; e_we = 1; e_rpd = pc + 32'd2; e_tk = 1; e_cyc = 2;
      end else if (ins[15:8] == 8'h97 && ins[7:4] == 4'd2) begin
         e_tag = "R9";
         e_pc = rp; e_tk = 1; e_cyc = 2;
      end else begin
         e_tag = "R10";
         e_ill = 1;
      end
      if (force_tag != "") e_tag = force_tag;
   endtask

   task automatic compare_all();
      chk(e_tag, "out_valid", 32'(out_valid), 32'(e_val));
      chk(e_tag, "pc_next",   pc_next,         e_pc);
      chk(e_tag, "rp_we",     32'(rp_we),      32'(e_we));
      chk(e_tag, "rp_wdata",  rp_wdata,        e_rpd);
      chk(e_tag, "taken",     32'(taken),      32'(e_tk));
      chk(e_tag, "cycles",    32'(cycles),     32'(e_cyc));
      chk(e_tag, "illegal",   32'(illegal),    32'(e_ill));
   endtask

   // One cycle: compare the previous result, then present new inputs.
   task automatic step(input logic v, input logic [15:0] ins, input logic [31:0] pc,
                       input logic [31:0] ri, input logic [31:0] rp,
                       input logic [3:0] f, input string force_tag);
      @(negedge clk);
      compare_all();
      in_valid = v; instr = ins; pc_cur = pc; ri_val = ri; rp_cur = rp; flags = f;
      model(v, ins, pc, ri, rp, f, force_tag);
      #1;
      chk("R7", "ri_sel", 32'(ri_sel), 32'(ins[3:0]));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #1000000;
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] ins;
      logic [31:0] pc;
      int          k;
      set_idle_exp("R1");
      repeat (3) @(negedge clk);
      // R1: outputs stay zero during reset
      compare_all();
      @(negedge clk);
      rst_n = 1'b1;
      set_idle_exp("R2");

      // R3 R4 R5: every condition code against every flag pattern
      for (int cc = 0; cc < 16; cc++) begin
         for (int f = 0; f < 16; f++) begin
            ins = {4'hE, 4'(cc), ((cc + f) % 2 == 0) ? 8'hF3 : 8'h2A};
            step(1, ins, 32'h0000_1000 + 32'(f * 64), 32'h0, 32'h0, 4'(f), "");
         end
      end
      step(0, 16'h0, 0, 0, 0, 0, "");
      // R11: wrap both directions
      step(1, 16'hE080, 32'h0000_0010, 0, 0, 0, "R11");
      step(1, 16'hE07F, 32'hFFFF_FFF0, 0, 0, 0, "R11");
      step(1, 16'hD3FF, 32'hFFFF_FFFE, 0, 0, 0, "R11");
      step(1, 16'hD400, 32'h0000_0004, 0, 0, 0, "R11");
      // R6: relative calls
      step(1, 16'hD000, 32'h0000_2000, 0, 0, 0, "R6");
      step(1, 16'hD7FF, 32'h0000_2000, 0, 0, 0, "R6");
      step(1, 16'hD123, 32'h1234_5678, 0, 0, 0, "R6");
      // R7 R8 R9: indirect forms
      step(1, 16'h9705, 32'h0000_3000, 32'hCAFE_0100, 32'h1111_2222, 0, "R7");
      step(1, 16'h971A, 32'h0000_3002, 32'hBEEF_0200, 32'h1111_2222, 0, "R8");
      step(1, 16'h972F, 32'h0000_3004, 32'hBEEF_0200, 32'h4444_8888, 0, "R9");
      // R10: undecoded encodings
      step(1, 16'h9730, 32'h0000_4000, 32'h5, 32'h6, 4'hF, "R10");
      step(1, 16'h97F0, 32'h0000_4000, 32'h5, 32'h6, 4'hF, "R10");
      step(1, 16'h9600, 32'h0000_4000, 32'h5, 32'h6, 4'hF, "R10");
      step(1, 16'hD800, 32'hFFFF_FFFE, 32'h5, 32'h6, 4'hF, "R10");
      step(1, 16'h0000, 32'h0000_4000, 32'h5, 32'h6, 4'hF, "R10");
      step(0, 16'h0, 0, 0, 0, 0, "R2");

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         k = int'($urandom % 6);
         pc = $urandom;
         case (k)
            0: ins = {4'hE, 12'($urandom)};
            1: ins = {5'b11010, 11'($urandom)};
            2: ins = {8'h97, 4'($urandom % 4), 4'($urandom)};
            3: ins = 16'($urandom);
            default: ins = 16'($urandom);
         endcase
         step(k != 5, ins, pc, $urandom, $urandom, 4'($urandom), "");
      end
      step(0, 16'h0, 0, 0, 0, 0, "R2");
      @(negedge clk);
      compare_all();
      summary();
      $finish;
   end

endmodule